// File: doc/BRIEF.md
# Dual-Port Namespace Reservation Arbiter

This block keeps the registration and reservation state of a single shared storage namespace that two host ports can reach. Each port sends reservation requests on its own valid/ready channel: join the registrant set, leave it, take a reservation of a chosen type, give it up, or forcibly clear another port's reservation. The block holds at most one active reservation, with its type and its holder, and it answers every accepted request with a one-cycle status response on that port's response lines.

Alongside the request channels, an access-check channel gives a port index and a read/write flag. One cycle later the block returns grant or deny, based on that port's role (holder, registrant, or outsider) under the active reservation type. The reservation state is cleared only by the power-on input. The controller reset input restarts the handshake and the check pipeline and leaves the reservation state as it is.

Back-pressure rule: when several ports are valid in the same cycle, `req_ready` is high for the lowest-numbered valid port only. A port holds `req_valid` and its fields steady until it sees `req_ready`. While `rst_n` or `pwr_on_n` is low, no request is accepted.

Top module: `ns_rsv_arbiter`

## Requirements
- R1: At most one request is accepted per cycle, and the lowest-numbered valid port wins. The accepted port's `rsp_valid` bit is high in exactly the cycle after acceptance.
- R2: Opcodes are 0 register, 1 unregister, 2 acquire, 3 release, 4 preempt, 5 preempt-and-abort. Status codes are 0 ok, 1 conflict, 2 error. Register always answers ok. Unregister from a port that is not registered answers error.
- R3: Acquire from an unregistered port answers conflict. On a free namespace it answers ok and the port becomes holder. If the requester already holds a reservation of the same type, it answers ok with no change. Otherwise it answers conflict.
- R4: Release answers ok and frees the reservation only when the requester is a holder and the type field equals the active type. Otherwise it answers error and leaves the state unchanged.
- R5: Unregistering the holder under a single-holder type (1 to 4) frees the reservation. Under the all-registrants types (5, 6), the reservation is freed when the last registrant leaves.
- R6: Preempt from a registered port frees an active reservation and answers ok. With no reservation it answers error, and from an unregistered port it answers conflict. The preempt-and-abort opcode also raises `rsp_abort` with its ok response.
- R7: While no reservation is active, every read and every write is granted.
- R8: Type 1 (write-exclusive, one holder): the holder reads and writes. All other ports may read but not write.
- R9: Type 2 (exclusive-access, one holder): only the holder is granted. Every other port is denied both reads and writes.
- R10: Types 3 and 4 (registrants-only variants): registrants read and write. Outsiders may read under type 3, and are denied everything under type 4.
- R11: Types 5 and 6 (all-registrants variants): every registrant is a holder, so it reads, writes and may release. Outsiders may read under type 5, and are denied everything under type 6.
- R12: Holding `rst_n` low does not change registrations or the reservation. Only `pwr_on_n` clears them.
- R13: An access result appears on `acc_valid` exactly one cycle after `chk_valid`, with exactly one of grant and deny high. It reflects the state before any request accepted in the same cycle.
- R14: Acquire from a registered port with a type code of 0 or 7 answers error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_n | input | 1 | Power-on clear, active low; the only input that clears reservation state |
| rst_n | input | 1 | Controller reset, active low; clears the handshake and check pipeline only |
| req_valid | input | NP | Per-port request valid |
| req_ready | output | NP | Per-port request ready |
| req_op | input | 3*NP | Per-port opcode, port p in bits [3p+2:3p] |
| req_type | input | 3*NP | Per-port reservation type, port p in bits [3p+2:3p] |
| rsp_valid | output | NP | Per-port response strobe |
| rsp_status | output | 2*NP | Per-port status, port p in bits [2p+1:2p] |
| rsp_abort | output | NP | Per-port abort flag, set with a preempt-and-abort ok |
| chk_valid | input | 1 | Access check strobe |
| chk_port | input | PW | Port index under check |
| chk_write | input | 1 | 1 for a write access, 0 for a read |
| acc_valid | output | 1 | Access result strobe |
| acc_grant | output | 1 | Access granted |
| acc_deny | output | 1 | Access denied |

## Verification
Two events can fall in the same cycle: an access check and a request that changes the reservation. The bench provokes this by raising `chk_valid` in the same cycle an acquire is accepted. It expects the access result to reflect the free namespace, and a check one cycle later to reflect the new reservation. A second overlap comes from both ports raising `req_valid` in the same cycle. That case is judged by which port sees `req_ready`, which port gets a response one cycle later, and whether the held request of the losing port is served in the following cycle.

// File: rtl/ns_rsv_pkg.sv
package ns_rsv_pkg;

  localparam int OP_W   = 3;
  localparam int TYPE_W = 3;
  localparam int STAT_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_JOIN     = 3'd0,
    OP_LEAVE    = 3'd1,
    OP_TAKE     = 3'd2,
    OP_GIVE     = 3'd3,
    OP_SEIZE    = 3'd4,
    OP_SEIZE_AB = 3'd5
  } rsv_op_e;

  typedef enum logic [TYPE_W-1:0] {
    RT_NONE   = 3'd0,
    RT_WR_EX  = 3'd1,
    RT_ALL_EX = 3'd2,
    RT_WR_REG = 3'd3,
    RT_ALL_REG= 3'd4,
    RT_WR_ANY = 3'd5,
    RT_ALL_ANY= 3'd6
  } rsv_type_e;

  typedef enum logic [STAT_W-1:0] {
    ST_OK       = 2'd0,
    ST_CONFLICT = 2'd1,
    ST_ERROR    = 2'd2
  } rsv_stat_e;

  function automatic logic type_legal(input logic [TYPE_W-1:0] t);
    return (t >= 3'd1) && (t <= 3'd6);
  endfunction

  function automatic logic type_single(input logic [TYPE_W-1:0] t);
    return (t >= 3'd1) && (t <= 3'd4);
  endfunction

endpackage

// File: rtl/ns_rsv_req_pick.sv
module ns_rsv_req_pick #(
  parameter int NP = 2,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          en,
  input  logic [NP-1:0] valid,
  output logic [NP-1:0] ready,
  output logic [PW-1:0] sel,
  output logic          any
);

  always_comb begin
    ready = '0;
    sel   = '0;
    any   = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (en && valid[p] && !any) begin
        ready[p] = 1'b1;
        sel      = PW'(p);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ns_rsv_state.sv
module ns_rsv_state
  import ns_rsv_pkg::*;
#(
  parameter int NP = 2,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic              clk,
  input  logic              pwr_on_n,
  input  logic              go,
  input  logic [PW-1:0]     port,
  input  logic [OP_W-1:0]   op,
  input  logic [TYPE_W-1:0] rtype,
  output logic [STAT_W-1:0] status,
  output logic              abort,
  output logic [NP-1:0]     reg_mask,
  output logic              rsv_active,
  output logic [TYPE_W-1:0] rsv_type,
  output logic [PW-1:0]     holder
);

  logic [NP-1:0]     n_mask;
  logic              n_active;
  logic [TYPE_W-1:0] n_type;
  logic [PW-1:0]     n_holder;
  logic              is_reg;
  logic              is_hold;
  logic              single;

  assign single  = type_single(rsv_type);
  assign is_reg  = reg_mask[port];
  assign is_hold = rsv_active && (single ? (holder == port) : is_reg);

  always_comb begin
    n_mask   = reg_mask;
    n_active = rsv_active;
    n_type   = rsv_type;
    n_holder = holder;
    status   = ST_OK;
    abort    = 1'b0;
    unique case (op)
      OP_JOIN: n_mask[port] = 1'b1;
      OP_LEAVE: begin
        if (!is_reg) begin
          status = ST_ERROR;
        end else begin
          n_mask[port] = 1'b0;
          if (rsv_active && single && (holder == port)) n_active = 1'b0;
          if (rsv_active && !single && (n_mask == '0))  n_active = 1'b0;
        end
      end
      OP_TAKE: begin
        if (!is_reg)                       status = ST_CONFLICT;
        else if (!type_legal(rtype))       status = ST_ERROR;
        else if (!rsv_active) begin
          n_active = 1'b1;
          n_type   = rtype;
          n_holder = port;
        end
        else if (is_hold && rtype == rsv_type) status = ST_OK;
        else                                   status = ST_CONFLICT;
      end
      OP_GIVE: begin
        if (is_hold && rtype == rsv_type) n_active = 1'b0;
        else                              status   = ST_ERROR;
      end
      OP_SEIZE, OP_SEIZE_AB: begin
        if (!is_reg)          status = ST_CONFLICT;
        else if (!rsv_active) status = ST_ERROR;
        else begin
          n_active = 1'b0;
          abort    = (op == OP_SEIZE_AB);
        end
      end
      default: status = ST_ERROR;
    endcase
    if (!n_active) begin
      n_type   = RT_NONE;
      n_holder = '0;
    end
  end

  // Only the power-on input clears this state; controller reset never reaches it.
  always_ff @(posedge clk) begin
    if (!pwr_on_n) begin
      reg_mask   <= '0;
      rsv_active <= 1'b0;
      rsv_type   <= RT_NONE;
      holder     <= '0;
    end else if (go) begin
      reg_mask   <= n_mask;
      rsv_active <= n_active;
      rsv_type   <= n_type;
      holder     <= n_holder;
    end
  end

endmodule

// File: rtl/ns_rsv_access.sv
module ns_rsv_access
  import ns_rsv_pkg::*;
#(
  parameter int NP = 2,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic              clk,
  input  logic              rst_all_n,
  input  logic              chk_valid,
  input  logic [PW-1:0]     chk_port,
  input  logic              chk_write,
  input  logic [NP-1:0]     reg_mask,
  input  logic              rsv_active,
  input  logic [TYPE_W-1:0] rsv_type,
  input  logic [PW-1:0]     holder,
  output logic              acc_valid,
  output logic              acc_grant,
  output logic              acc_deny
);

  logic in_range, is_reg, is_hold, allow;

  assign in_range = (int'(chk_port) < NP);
  assign is_reg   = in_range && reg_mask[chk_port];
  assign is_hold  = rsv_active &&
                    (type_single(rsv_type) ? (in_range && holder == chk_port) : is_reg);

  always_comb begin
    if (!rsv_active || is_hold) begin
      allow = 1'b1;
    end else begin
      unique case (rsv_type)
        RT_WR_EX:   allow = !chk_write;
        RT_ALL_EX:  allow = 1'b0;
        RT_WR_REG:  allow = is_reg || !chk_write;
        RT_ALL_REG: allow = is_reg;
        RT_WR_ANY:  allow = !chk_write;
        default:    allow = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_all_n) begin
      acc_valid <= 1'b0;
      acc_grant <= 1'b0;
      acc_deny  <= 1'b0;
    end else begin
      acc_valid <= chk_valid;
      acc_grant <= chk_valid && allow;
      acc_deny  <= chk_valid && !allow;
    end
  end

endmodule

// File: rtl/ns_rsv_arbiter.sv
module ns_rsv_arbiter
  import ns_rsv_pkg::*;
#(
  parameter int NP = 2,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 pwr_on_n,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_valid,
  output logic [NP-1:0]        req_ready,
  input  logic [NP*OP_W-1:0]   req_op,
  input  logic [NP*TYPE_W-1:0] req_type,
  output logic [NP-1:0]        rsp_valid,
  output logic [NP*STAT_W-1:0] rsp_status,
  output logic [NP-1:0]        rsp_abort,
  input  logic                 chk_valid,
  input  logic [PW-1:0]        chk_port,
  input  logic                 chk_write,
  output logic                 acc_valid,
  output logic                 acc_grant,
  output logic                 acc_deny
);

  logic              rst_all_n;
  logic [PW-1:0]     sel;
  logic              go;
  logic [OP_W-1:0]   cur_op;
  logic [TYPE_W-1:0] cur_type;
  logic [STAT_W-1:0] st_status;
  logic              st_abort;
  logic [NP-1:0]     reg_mask;
  logic              rsv_active;
  logic [TYPE_W-1:0] rsv_type;
  logic [PW-1:0]     holder;

  assign rst_all_n = rst_n && pwr_on_n;
  assign cur_op    = req_op[sel*OP_W +: OP_W];
  assign cur_type  = req_type[sel*TYPE_W +: TYPE_W];

  ns_rsv_req_pick #(.NP(NP)) u_pick (
    .en    (rst_all_n),
    .valid (req_valid),
    .ready (req_ready),
    .sel   (sel),
    .any   (go)
  );

  ns_rsv_state #(.NP(NP)) u_state (
    .clk        (clk),
    .pwr_on_n   (pwr_on_n),
    .go         (go),
    .port       (sel),
    .op         (cur_op),
    .rtype      (cur_type),
    .status     (st_status),
    .abort      (st_abort),
    .reg_mask   (reg_mask),
    .rsv_active (rsv_active),
    .rsv_type   (rsv_type),
    .holder     (holder)
  );

  ns_rsv_access #(.NP(NP)) u_acc (
    .clk        (clk),
    .rst_all_n  (rst_all_n),
    .chk_valid  (chk_valid),
    .chk_port   (chk_port),
    .chk_write  (chk_write),
    .reg_mask   (reg_mask),
    .rsv_active (rsv_active),
    .rsv_type   (rsv_type),
    .holder     (holder),
    .acc_valid  (acc_valid),
    .acc_grant  (acc_grant),
    .acc_deny   (acc_deny)
  );

  always_ff @(posedge clk) begin
    if (!rst_all_n) begin
      rsp_valid  <= '0;
      rsp_status <= '0;
      rsp_abort  <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        rsp_valid[p] <= req_ready[p];
        if (req_ready[p]) begin
          rsp_status[p*STAT_W +: STAT_W] <= st_status;
          rsp_abort[p]                   <= st_abort;
        end else begin
          rsp_status[p*STAT_W +: STAT_W] <= '0;
          rsp_abort[p]                   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/ns_rsv_arbiter_chk.sv
module ns_rsv_arbiter_chk
  import ns_rsv_pkg::*;
#(
  parameter int NP = 2
) (
  input logic              clk,
  input logic              pwr_on_n,
  input logic              rst_n,
  input logic [NP-1:0]     req_valid,
  input logic [NP-1:0]     req_ready,
  input logic [NP-1:0]     rsp_valid,
  input logic              chk_valid,
  input logic              acc_valid,
  input logic              acc_grant,
  input logic              acc_deny,
  input logic [NP-1:0]     reg_mask,
  input logic              rsv_active,
  input logic [TYPE_W-1:0] rsv_type
);

  assert_one_ready_R1: assert property (@(posedge clk)
    disable iff (!rst_n || !pwr_on_n) $onehot0(req_ready));

  for (genvar p = 0; p < NP; p++) begin : g_port
    assert_ready_needs_valid_R1: assert property (@(posedge clk)
      disable iff (!rst_n || !pwr_on_n) req_ready[p] |-> req_valid[p]);
    assert_rsp_after_accept_R1: assert property (@(posedge clk)
      disable iff (!rst_n || !pwr_on_n) (req_valid[p] && req_ready[p]) |=> rsp_valid[p]);
    assert_no_rsp_unaccepted_R1: assert property (@(posedge clk)
      disable iff (!rst_n || !pwr_on_n) !(req_valid[p] && req_ready[p]) |=> !rsp_valid[p]);
  end

  assert_free_grants_R7: assert property (@(posedge clk)
    disable iff (!rst_n || !pwr_on_n) (chk_valid && !rsv_active) |=> acc_grant);

  assert_state_kept_R12: assert property (@(posedge clk)
    disable iff (!pwr_on_n)
    !rst_n |=> ($stable(reg_mask) && $stable(rsv_active) && $stable(rsv_type)));

  assert_acc_timing_R13: assert property (@(posedge clk)
    disable iff (!rst_n || !pwr_on_n) chk_valid |=> acc_valid);

  assert_grant_xor_R13: assert property (@(posedge clk)
    disable iff (!rst_n || !pwr_on_n) acc_valid |-> (acc_grant != acc_deny));

  assert_idle_quiet_R13: assert property (@(posedge clk)
    disable iff (!rst_n || !pwr_on_n) !acc_valid |-> (!acc_grant && !acc_deny));

  assert_legal_type_R14: assert property (@(posedge clk)
    disable iff (!pwr_on_n) rsv_active |-> type_legal(rsv_type));

endmodule

bind ns_rsv_arbiter ns_rsv_arbiter_chk #(.NP(NP)) u_chk (
  .clk        (clk),
  .pwr_on_n   (pwr_on_n),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .chk_valid  (chk_valid),
  .acc_valid  (acc_valid),
  .acc_grant  (acc_grant),
  .acc_deny   (acc_deny),
  .reg_mask   (reg_mask),
  .rsv_active (rsv_active),
  .rsv_type   (rsv_type)
);

// File: tb/ns_rsv_arbiter_tb.sv
module ns_rsv_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NV = 44;

  logic          clk = 1'b0;
  logic          pwr_on_n = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_ready;
  logic [5:0]    req_op = '0;
  logic [5:0]    req_type = '0;
  logic [NP-1:0] rsp_valid;
  logic [3:0]    rsp_status;
  logic [NP-1:0] rsp_abort;
  logic          chk_valid = 1'b0;
  logic [0:0]    chk_port = '0;
  logic          chk_write = 1'b0;
  logic          acc_valid, acc_grant, acc_deny;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_rsv_arbiter #(.NP(NP)) u_dut (.*);

  // vector: kind[14] port[13] op[12:10] type[9:7] write[6] expect[5:4] req[3:0]
  function automatic logic [14:0] mk(int k, int p, int o, int t, int w, int e, int r);
    return {k[0], p[0], o[2:0], t[2:0], w[0], e[1:0], r[3:0]};
  endfunction

  localparam logic [14:0] VEC [NV] = '{
    mk(1,0,0,0,0,1,7),   // R7 read free
    mk(1,1,0,0,1,1,7),   // R7 write free
    mk(0,0,2,1,0,1,3),   // R3 acquire unregistered -> conflict
    mk(0,0,0,0,0,0,2),   // R2 register
    mk(0,1,1,0,0,2,2),   // R2 unregister while not registered
    mk(0,0,2,7,0,2,14),  // R14 illegal type
    mk(0,0,2,1,0,0,3),   // R3 acquire write-exclusive
    mk(0,1,0,0,0,0,2),   // R2 register p1
    mk(1,1,0,0,0,1,8),   // R8 registrant read
    mk(1,1,0,0,1,0,8),   // R8 registrant write denied
    mk(1,0,0,0,1,1,8),   // R8 holder write
    mk(0,1,2,1,0,1,3),   // R3 held by other -> conflict
    mk(0,1,3,1,0,2,4),   // R4 release by non-holder
    mk(0,0,3,2,0,2,4),   // R4 release type mismatch
    mk(0,0,2,1,0,0,3),   // R3 re-acquire same type
    mk(1,1,0,0,1,0,4),   // R4 state unchanged after failed releases
    mk(0,0,3,1,0,0,4),   // R4 release ok
    mk(1,1,0,0,1,1,7),   // R7 freed
    mk(0,0,2,2,0,0,3),   // R3 acquire exclusive-access
    mk(1,1,0,0,0,0,9),   // R9 registrant read denied
    mk(1,0,0,0,0,1,9),   // R9 holder read
    mk(0,1,4,0,0,0,6),   // R6 preempt
    mk(1,1,0,0,1,1,6),   // R6 freed by preempt
    mk(0,1,4,0,0,2,6),   // R6 preempt with nothing active
    mk(0,1,2,3,0,0,3),   // R3 p1 takes type 3
    mk(1,0,0,0,1,1,10),  // R10 registrant write under type 3
    mk(0,1,1,0,0,0,5),   // R5 holder unregisters
    mk(0,0,2,4,0,0,5),   // R5 namespace free again
    mk(1,1,0,0,0,0,10),  // R10 outsider read under type 4
    mk(1,0,0,0,1,1,10),  // R10 holder write under type 4
    mk(0,1,4,0,0,1,6),   // R6 preempt from unregistered
    mk(0,0,3,4,0,0,4),   // R4 release type 4
    mk(0,0,2,5,0,0,11),  // R11 acquire type 5
    mk(1,1,0,0,0,1,11),  // R11 outsider read type 5
    mk(1,1,0,0,1,0,11),  // R11 outsider write type 5
    mk(0,1,0,0,0,0,2),   // R2 p1 registers
    mk(0,1,3,5,0,0,11),  // R11 any registrant releases
    mk(0,1,2,6,0,0,11),  // R11 p1 takes type 6
    mk(1,0,0,0,1,1,11),  // R11 other registrant is holder
    mk(0,1,1,0,0,0,5),   // R5 one registrant leaves
    mk(1,1,0,0,0,0,11),  // R11 outsider denied type 6
    mk(0,0,1,0,0,0,5),   // R5 last registrant leaves
    mk(1,1,0,0,1,1,5),   // R5 freed with last registrant
    mk(0,0,0,0,0,0,2)    // R2 p0 registers again
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req1(int p, int o, int t);
    @(negedge clk);
    req_valid = '0;
    req_valid[p] = 1'b1;
    req_op[p*3 +: 3] = o[2:0];
    req_type[p*3 +: 3] = t[2:0];
    @(posedge clk);
    #1;
    req_valid = '0;
  endtask

  task automatic chk1(int p, int w);
    @(negedge clk);
    chk_valid = 1'b1;
    chk_port  = p[0:0];
    chk_write = w[0];
    @(posedge clk);
    #1;
    chk_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset rsp_valid", int'(rsp_valid), 0);
    check("R13 reset acc_valid", int'(acc_valid), 0);
    @(negedge clk);
    pwr_on_n = 1'b1;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      automatic logic [14:0] v = VEC[i];
      automatic int p = int'(v[13]);
      automatic string tg = $sformatf("R%0d vec%0d", v[3:0], i);
      if (v[14]) begin
        chk1(p, int'(v[6]));
        check(tg, {30'd0, acc_valid, acc_grant}, {30'd0, 1'b1, v[4]});
        check(tg, int'(acc_deny), int'(!v[4]));
      end else begin
        req1(p, int'(v[12:10]), int'(v[9:7]));
        check(tg, int'(rsp_valid[p]), 1);
        check(tg, int'(rsp_status[p*2 +: 2]), int'(v[5:4]));
      end
    end

    // R10: p0 holds type 3, p1 is an outsider
    req1(0, 2, 3);
    check("R10 acquire type 3", int'(rsp_status[1:0]), 0);
    chk1(1, 0);
    check("R10 outsider read type 3", int'(acc_grant), 1);
    chk1(1, 1);
    check("R10 outsider write type 3", int'(acc_grant), 0);

    // R12: controller reset keeps the reservation
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 2'b10;
    req_op[5:3] = 3'd4;
    @(posedge clk);
    #1;
    check("R12 no ready in reset", int'(req_ready), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    rst_n = 1'b1;
    chk1(1, 1);
    check("R12 reservation survives reset", int'(acc_deny), 1);
    chk1(0, 1);
    check("R12 holder survives reset", int'(acc_grant), 1);

    // R1: both ports valid together; p0 releases, p1 registers
    @(negedge clk);
    req_valid = 2'b11;
    req_op = {3'd0, 3'd3};
    req_type = {3'd0, 3'd3};
    #1;
    check("R1 ready to lowest port", int'(req_ready), 1);
    @(posedge clk);
    #1;
    check("R1 response on winner", int'(rsp_valid), 1);
    check("R4 release status", int'(rsp_status[1:0]), 0);
    @(negedge clk);
    req_valid = 2'b10;
    #1;
    check("R1 held request now ready", int'(req_ready), 2);
    @(posedge clk);
    #1;
    req_valid = '0;
    check("R1 loser served next", int'(rsp_valid), 2);

    // R13: check in the same cycle as an acquire sees the old state
    @(negedge clk);
    req_valid = 2'b01;
    req_op[2:0] = 3'd2;
    req_type[2:0] = 3'd2;
    chk_valid = 1'b1;
    chk_port = 1'b1;
    chk_write = 1'b0;
    @(posedge clk);
    #1;
    req_valid = '0;
    chk_valid = 1'b0;
    check("R13 same-cycle check sees free", int'(acc_grant), 1);
    chk1(1, 0);
    check("R13 next check sees type 2", int'(acc_deny), 1);

    // R6: preempt-and-abort raises the abort flag
    req1(1, 5, 0);
    check("R6 preempt-abort status", int'(rsp_status[3:2]), 0);
    check("R6 abort flag", int'(rsp_abort[1]), 1);

    // R12: power-on clears everything
    req1(0, 2, 2);
    @(negedge clk);
    pwr_on_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    pwr_on_n = 1'b1;
    chk1(1, 1);
    check("R12 power-on clears reservation", int'(acc_grant), 1);
    req1(0, 2, 1);
    check("R3 registration cleared by power-on", int'(rsp_status[1:0]), 1);

    finish_run();
  end

endmodule